// File: doc/BRIEF.md
# Fractional clock-enable divider with deferred ratio commit

This block turns a fast input clock into an enable pulse stream whose average rate is the input rate scaled by a programmable fraction, numerator over denominator. A phase accumulator adds the numerator on every enabled cycle. When the sum reaches the denominator, the block emits one pulse and takes the denominator back off.

Software writes a 32-bit ratio word through a plain write/read port, and may do so at any moment. The word goes into a holding register. It moves into the running divider only while the output gate is on and the downstream clock selector has this divider chosen. Until that happens, the divider keeps producing the previously accepted ratio, while the register already reads back the new word. A pending flag shows that a write is waiting. An error flag shows that the waiting word is unusable; while it is raised, the output is held low.

Top module: `frac_clk_div`

## Requirements
- R1: The ratio word carries the numerator in bits [31:16] and the denominator in bits [15:0]. After reset it reads 0x0BB8EA60 (3000/60000), so the output gives one pulse every 20 enabled cycles.
- R2: A read returns the most recently written word from the cycle after the write, whether or not that word has been accepted.
- R3: With the gate on and no commit in the window, any run of `den` consecutive cycles holds exactly `num` output pulses.
- R4: A waiting word is accepted only in a cycle where `gate_en` is 1 and `mux_sel` equals the parameter `SEL_ID`. Until then the output keeps the old ratio.
- R5: A write sets `pending`. The first cycle in which both conditions of R4 hold commits the word and clears `pending`.
- R6: A commit zeroes the phase accumulator. After committing num/den, the first pulse appears on the ceil(den/num)-th cycle after the commit edge, whatever phase came before.
- R7: A waiting word with a numerator of 0, or a numerator above its denominator, is never committed. While it waits, `cfg_err` is 1 and the output is 0. A later legal write is committed normally.
- R8: While `gate_en` is 0 the output is 0. Both the committed ratio and any waiting word survive, and the old ratio resumes when the gate returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the ratio word |
| wr_data | input | 32 | Ratio word to write: numerator [31:16], denominator [15:0] |
| rd_data | output | 32 | Last written ratio word |
| gate_en | input | 1 | Output gate enable |
| mux_sel | input | SEL_W | Downstream selector setting; equal to SEL_ID means this divider is in use |
| clk_en_out | output | 1 | Fractional enable pulse, one input cycle wide |
| pending | output | 1 | A written word waits for commit |
| cfg_err | output | 1 | The waiting word is illegal |

## Verification
The hardest state to reach from the ports is a commit that lands while the accumulator holds a non-zero leftover phase. Only in that state does a missing accumulator clear change the first pulse position. The bench first runs a 4/5 ratio for a few cycles to leave a leftover phase. It then commits 1/5 and checks the exact cycle of the first pulse. The deferred-commit path is reached by writing with the gate off, then opening the gate with the selector pointed elsewhere, and only then selecting this divider, measuring the pulse rate at each stage.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int RATIO_W = 16;
  localparam int CFG_W   = 2 * RATIO_W;

  typedef struct packed {
    logic [RATIO_W-1:0] num;
    logic [RATIO_W-1:0] den;
  } ratio_t;
endpackage

// File: rtl/frac_div_rst_sync.sv
module frac_div_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/frac_div_shadow.sv
module frac_div_shadow
  import frac_div_pkg::*;
#(
  parameter logic [CFG_W-1:0] CFG_RESET = 32'h0BB8_EA60
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  ratio_t wr_word,
  input  logic   sel_hit,
  output ratio_t shadow,
  output ratio_t active,
  output logic   pend,
  output logic   commit,
  output logic   bad
);
  ratio_t shadow_q, shadow_d;
  ratio_t active_q, active_d;
  logic   pend_q, pend_d;
  logic   illegal;

  assign illegal = (shadow_q.num == '0) || (shadow_q.num > shadow_q.den);
  assign commit  = pend_q && sel_hit && !illegal;
  assign bad     = pend_q && illegal;

  always_comb begin
    shadow_d = shadow_q;
    active_d = active_q;
    pend_d   = pend_q;
    if (commit) begin
      active_d = shadow_q;
      pend_d   = 1'b0;
    end
    if (wr_en) begin
      shadow_d = wr_word;
      pend_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= ratio_t'(CFG_RESET);
      active_q <= ratio_t'(CFG_RESET);
      pend_q   <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
      pend_q   <= pend_d;
    end
  end

  assign shadow = shadow_q;
  assign active = active_q;
  assign pend   = pend_q;
endmodule

// File: rtl/frac_div_accum.sv
module frac_div_accum #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         hold,
  input  logic         clear,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         pulse
);
  logic [W-1:0] acc_q, acc_d;
  logic [W:0]   sum;
  logic [W:0]   wrapped;
  logic         fire;
  logic         pulse_q, pulse_d;

  assign sum     = {1'b0, acc_q} + {1'b0, num};
  assign fire    = sum >= {1'b0, den};
  assign wrapped = sum - {1'b0, den};

  always_comb begin
    acc_d   = acc_q;
    pulse_d = 1'b0;
    if (clear) begin
      acc_d = '0;
    end else if (run) begin
      acc_d   = fire ? wrapped[W-1:0] : sum[W-1:0];
      pulse_d = fire && !hold;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import frac_div_pkg::*;
#(
  parameter int               SEL_W     = 2,
  parameter int               SEL_ID    = 1,
  parameter logic [CFG_W-1:0] CFG_RESET = 32'h0BB8_EA60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] rd_data,
  input  logic             gate_en,
  input  logic [SEL_W-1:0] mux_sel,
  output logic             clk_en_out,
  output logic             pending,
  output logic             cfg_err
);
  localparam logic [SEL_W-1:0] SEL_MATCH = SEL_W'(SEL_ID);

  logic   rst_sync_n;
  logic   sel_hit;
  logic   commit;
  ratio_t shadow;
  ratio_t active;

  assign sel_hit = gate_en && (mux_sel == SEL_MATCH);

  frac_div_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  frac_div_shadow #(.CFG_RESET(CFG_RESET)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_word (ratio_t'(wr_data)),
    .sel_hit (sel_hit),
    .shadow  (shadow),
    .active  (active),
    .pend    (pending),
    .commit  (commit),
    .bad     (cfg_err)
  );

  frac_div_accum #(.W(RATIO_W)) u_accum (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (gate_en),
    .hold  (cfg_err),
    .clear (commit),
    .num   (active.num),
    .den   (active.den),
    .pulse (clk_en_out)
  );

  assign rd_data = shadow;
endmodule

// File: rtl/frac_div_checker.sv
module frac_div_checker #(
  parameter int CFG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [CFG_W-1:0] wr_data,
  input logic [CFG_W-1:0] rd_data,
  input logic             gate_en,
  input logic             sel_hit,
  input logic             pending,
  input logic             cfg_err,
  input logic             clk_en_out
);
  AST_RD_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data)); // R2
  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pending); // R5
  AST_HOLD_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !wr_en && !sel_hit |=> pending && $stable(rd_data)); // R4
  AST_COMMIT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !wr_en && sel_hit && !cfg_err |=> !pending); // R5
  AST_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> !clk_en_out); // R8
  AST_ERR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !clk_en_out); // R7
  AST_ERR_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err && !wr_en |=> cfg_err && pending); // R7
endmodule

bind frac_clk_div frac_div_checker #(.CFG_W(32)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .gate_en    (gate_en),
  .sel_hit    (sel_hit),
  .pending    (pending),
  .cfg_err    (cfg_err),
  .clk_en_out (clk_en_out)
);

// File: tb/frac_clk_div_bench.sv
module frac_clk_div_bench;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        gate_en;
  logic [1:0]  mux_sel;
  logic        clk_en_out;
  logic        pending;
  logic        cfg_err;

  int n_checks;
  int n_fail;
  bit finished;

  frac_clk_div #(.SEL_W(2), .SEL_ID(1)) u_frac_clk_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .gate_en    (gate_en),
    .mux_sel    (mux_sel),
    .clk_en_out (clk_en_out),
    .pending    (pending),
    .cfg_err    (cfg_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input int num, input int den);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = {num[15:0], den[15:0]};
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic count_pulses(input int cycles, output int cnt);
    cnt = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      cnt += int'(clk_en_out);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int cnt;
    n_checks = 0;
    n_fail   = 0;
    finished = 0;
    rst_n    = 1'b0;
    wr_en    = 1'b0;
    wr_data  = '0;
    gate_en  = 1'b1;
    mux_sel  = 2'd1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state and default divide-by-20
    check(rd_data == 32'h0BB8EA60, "R1 reset word", rd_data, 32'h0BB8EA60);
    check(!pending && !cfg_err, "R1 reset flags", {pending, cfg_err}, 0);
    count_pulses(200, cnt);
    check(cnt == 10, "R1 default rate", cnt, 10);

    // R8/R2: write 1/2 with gate off
    gate_en = 1'b0;
    write_cfg(1, 2);
    check(rd_data == {16'd1, 16'd2}, "R2 readback", rd_data, {16'd1, 16'd2});
    check(pending, "R5 pending set", pending, 1);
    count_pulses(40, cnt);
    check(cnt == 0, "R8 gate off low", cnt, 0);
    check(pending, "R8 pending kept", pending, 1);

    // R4: gate on, mux elsewhere -> old ratio
    mux_sel = 2'd2;
    gate_en = 1'b1;
    count_pulses(200, cnt);
    check(cnt == 10, "R4 old ratio kept", cnt, 10);
    check(pending, "R4 no commit", pending, 1);

    // R5: select this divider -> commit
    mux_sel = 2'd1;
    @(negedge clk);
    check(!pending, "R5 pending cleared", pending, 0);
    count_pulses(20, cnt);
    check(cnt == 10, "R5 new ratio", cnt, 10);

    // R8: ratio survives gate toggling
    gate_en = 1'b0;
    count_pulses(10, cnt);
    check(cnt == 0, "R8 gate low", cnt, 0);
    gate_en = 1'b1;
    count_pulses(20, cnt);
    check(cnt == 10, "R8 ratio resumes", cnt, 10);

    // R6: commit clears leftover phase
    write_cfg(4, 5);
    repeat (7) @(negedge clk);
    write_cfg(1, 5);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(clk_en_out == (i == 5), "R6 first pulse position", clk_en_out, (i == 5));
    end

    // R7: illegal words
    write_cfg(0, 5);
    check(cfg_err && pending, "R7 zero numerator flagged", {cfg_err, pending}, 3);
    count_pulses(20, cnt);
    check(cnt == 0, "R7 output held low", cnt, 0);
    check(pending, "R7 not committed", pending, 1);
    write_cfg(7, 5);
    check(cfg_err, "R7 num above den flagged", cfg_err, 1);
    count_pulses(10, cnt);
    check(cnt == 0, "R7 output held low 2", cnt, 0);
    write_cfg(2, 5);
    @(negedge clk);
    check(!cfg_err && !pending, "R7 legal word commits", {cfg_err, pending}, 0);
    count_pulses(15, cnt);
    check(cnt == 6, "R7 legal rate", cnt, 6);

    // R3: sweep of small ratios
    for (int d = 1; d <= 6; d++) begin
      for (int n = 1; n <= d; n++) begin
        write_cfg(n, d);
        @(negedge clk);
        check(!pending, "R5 sweep commit", pending, 0);
        count_pulses(3 * d, cnt);
        check(cnt == 3 * n, "R3 sweep rate", cnt, 3 * n);
      end
    end

    // R3: large ratio 256/12375
    write_cfg(256, 12375);
    @(negedge clk);
    count_pulses(12375, cnt);
    check(cnt == 256, "R3 256/12375 rate", cnt, 256);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule